// File: doc/BRIEF.md
# Data-side fault status and fault address capture

This block holds the status word that a load/store unit fills in when a data access traps, together with the virtual address of the access. Each trap arrives as a one-cycle strobe with a trap class and a bundle of attributes: the TLB selector and entry index, the write, privilege, nonfaulting and context bits, a 7-bit fault-type vector, an internal-ASI flag, the address space identifier, a group of error flags and the faulting address. Software reads every stored field from the outputs and can pulse a clear to drop the record.

The block does not simply latch the newest event. It chooses one of eight update rows from the incoming trap class and from what it already holds: no record, a valid exception or fault record, or a pending TLB-miss record. Each row tells each field to load, hold, or be forced to 0 or 1. As a result, an access exception and a fault can overwrite each other and raise an overwrite flag. A miss record stays marked once a later exception or fault lands on it. The fault-type vector is filtered on entry, so its reserved bits never appear.

Top module: `dfault_status`

## Requirements
- R1: After reset every output is 0.
- R2: The class code is 0 for TLB miss, 1 for access exception, 2 for protection, 3 for physical watchpoint, 4 for virtual watchpoint, 5 for privileged action, 6 for misaligned and 7 for access error. A miss in any state sets TM=1, FV=0 and OW=0 and loads the attribute bits and the address. FT, ASI, TLB selector/index and the error flags are held.
- R3: An exception with FV=0 and TM=0 sets FV=1, OW=0 and TM=0. It loads the attributes, the filtered FT, the ASI and the address, and holds the TLB selector/index and the error flags.
- R4: A class 2 to 6 trap with FV=0 and TM=0 sets FV=1, OW=0 and TM=0 and loads the attributes, the ASI and the address. FT, TLB selector/index and the error flags are held.
- R5: A class 7 trap with FV=0 and TM=0 does everything R4 does and also loads the TLB selector/index and the error flags.
- R6: An exception with FV=1 and TM=0 sets FV=1 and OW=1. It loads the attributes, the filtered FT, the ASI and the address, and holds TM, the TLB selector/index and the error flags.
- R7: A class 2 to 7 trap with FV=1 and TM=0 sets FV=1 and OW=1. It loads the TLB selector/index, the attributes, the ASI, the error flags and the address, and holds FT and TM.
- R8: An exception with TM=1 sets FV=1, holds OW and TM=1, loads the attributes, the filtered FT, the ASI and the address, and holds the TLB selector/index and the error flags.
- R9: A class 2 to 7 trap with TM=1 sets FV=1, holds OW and TM=1, loads the TLB selector/index, the attributes, the ASI, the error flags and the address, and holds FT.
- R10: A stored FT has bits 6 and 5 always 0. Bit 4 is 0 whenever the internal-ASI input is 1. Bits 3:0 are kept as given, and several bits may be set at once.
- R11: A clear pulse with no trap makes FV, OW and TM 0 on the next cycle and leaves every other field unchanged.
- R12: When a trap and a clear arrive in the same cycle, the trap's row is applied, chosen from the contents held before the edge, and the clear is dropped.
- R13: With neither a trap nor a clear, every field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_vld | input | 1 | Trap event strobe |
| trap_cls | input | 3 | Trap class code (R2) |
| ev_tlb_sel | input | TLBN_W | TLB selector of the access |
| ev_tlb_idx | input | IDX_W | TLB entry index |
| ev_write | input | 1 | Access was a write |
| ev_priv | input | 1 | Access was privileged |
| ev_nofault | input | 1 | Access was a nonfaulting load |
| ev_ctx | input | CTX_W | Context selector |
| ev_ft | input | 7 | Raw fault-type vector |
| ev_int_asi | input | 1 | Access used an internal ASI |
| ev_asi | input | ASI_W | Address space identifier |
| ev_err | input | ERR_W | Error flags bundle |
| ev_va | input | VA_W | Faulting virtual address |
| sw_clr | input | 1 | Software clear of FV, OW and TM |
| st_fv | output | 1 | Fault record valid |
| st_ow | output | 1 | Overwrite flag |
| st_tm | output | 1 | TLB-miss record flag |
| st_write | output | 1 | Stored write bit |
| st_priv | output | 1 | Stored privilege bit |
| st_nofault | output | 1 | Stored nonfaulting bit |
| st_ctx | output | CTX_W | Stored context |
| st_ft | output | 7 | Stored fault type |
| st_asi | output | ASI_W | Stored ASI |
| st_tlb_sel | output | TLBN_W | Stored TLB selector |
| st_tlb_idx | output | IDX_W | Stored TLB index |
| st_err | output | ERR_W | Stored error flags |
| st_va | output | VA_W | Fault address |

## Verification
The hardest rows to reach are the ones that land on a miss record. Rows R8 and R9 need a miss first, and the record must then keep TM across a later exception and fault. Row R12 needs a clear and a trap in the same cycle while FV and TM are still set. The stimulus table walks the register through a planned chain of states: fresh exception, fault on a record, exception on a record, clears, a miss over a valid record, an exception and a fault on the miss, and a miss on a miss. Each data field comes from a pattern tied to the step number. The expected value of a field is therefore just the number of the step that last loaded it, which makes every keep and every load visible.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

  localparam int FT_W = 7;

  typedef enum logic [2:0] {
    CLS_MISS     = 3'd0,
    CLS_EXC      = 3'd1,
    CLS_PROT     = 3'd2,
    CLS_PA_WP    = 3'd3,
    CLS_VA_WP    = 3'd4,
    CLS_PRIV     = 3'd5,
    CLS_MISALIGN = 3'd6,
    CLS_ACC_ERR  = 3'd7
  } trap_cls_e;

  typedef enum logic [1:0] {
    OP_KEEP = 2'd0,
    OP_LOAD = 2'd1,
    OP_ZERO = 2'd2,
    OP_ONE  = 2'd3
  } fld_op_e;

  typedef enum logic [2:0] {
    ROW_MISS,
    ROW_FRESH_EXC,
    ROW_FRESH_FLT,
    ROW_FRESH_AERR,
    ROW_EXC_ON_REC,
    ROW_FLT_ON_REC,
    ROW_EXC_ON_MISS,
    ROW_FLT_ON_MISS
  } upd_row_e;

  typedef struct packed {
    fld_op_e tlb;
    fld_op_e fv;
    fld_op_e ow;
    fld_op_e attr;
    fld_op_e ft;
    fld_op_e tm;
    fld_op_e asi;
    fld_op_e err;
    fld_op_e va;
  } upd_pol_t;

  // Row choice from class and current record state
  function automatic upd_row_e pick_row(input logic [2:0] cls,
                                        input logic fv, input logic tm);
    upd_row_e r;
    if (cls == CLS_MISS)          r = ROW_MISS;
    else if (tm)                  r = (cls == CLS_EXC) ? ROW_EXC_ON_MISS : ROW_FLT_ON_MISS;
    else if (fv)                  r = (cls == CLS_EXC) ? ROW_EXC_ON_REC  : ROW_FLT_ON_REC;
    else if (cls == CLS_EXC)      r = ROW_FRESH_EXC;
    else if (cls == CLS_ACC_ERR)  r = ROW_FRESH_AERR;
    else                          r = ROW_FRESH_FLT;
    return r;
  endfunction

  // Per-field action for each row
  function automatic upd_pol_t row_policy(input upd_row_e r);
    upd_pol_t p;
    p = '{tlb: OP_KEEP, fv: OP_KEEP, ow: OP_KEEP, attr: OP_LOAD, ft: OP_KEEP,
          tm: OP_KEEP, asi: OP_LOAD, err: OP_KEEP, va: OP_LOAD};
    case (r)
      ROW_MISS: begin
        p.fv = OP_ZERO; p.ow = OP_ZERO; p.tm = OP_ONE; p.asi = OP_KEEP;
      end
      ROW_FRESH_EXC: begin
        p.fv = OP_ONE; p.ow = OP_ZERO; p.tm = OP_ZERO; p.ft = OP_LOAD;
      end
      ROW_FRESH_FLT: begin
        p.fv = OP_ONE; p.ow = OP_ZERO; p.tm = OP_ZERO;
      end
      ROW_FRESH_AERR: begin
        p.fv = OP_ONE; p.ow = OP_ZERO; p.tm = OP_ZERO;
        p.tlb = OP_LOAD; p.err = OP_LOAD;
      end
      ROW_EXC_ON_REC: begin
        p.fv = OP_ONE; p.ow = OP_ONE; p.ft = OP_LOAD;
      end
      ROW_FLT_ON_REC: begin
        p.fv = OP_ONE; p.ow = OP_ONE; p.tlb = OP_LOAD; p.err = OP_LOAD;
      end
      ROW_EXC_ON_MISS: begin
        p.fv = OP_ONE; p.tm = OP_ONE; p.ft = OP_LOAD;
      end
      default: begin
        p.fv = OP_ONE; p.tm = OP_ONE; p.tlb = OP_LOAD; p.err = OP_LOAD;
      end
    endcase
    return p;
  endfunction

  // Fault-type entry filter: reserved bits dropped, nonfault-only bit
  // suppressed for internal address spaces
  function automatic logic [FT_W-1:0] ft_filter(input logic [FT_W-1:0] raw,
                                                 input logic int_asi);
    logic [FT_W-1:0] f;
    f = raw & 7'h1F;
    if (int_asi) f[4] = 1'b0;
    return f;
  endfunction

  // The all-hold policy, optionally dropping the status flags
  function automatic upd_pol_t idle_policy(input logic clr);
    upd_pol_t p;
    p = '{tlb: OP_KEEP, fv: OP_KEEP, ow: OP_KEEP, attr: OP_KEEP, ft: OP_KEEP,
          tm: OP_KEEP, asi: OP_KEEP, err: OP_KEEP, va: OP_KEEP};
    if (clr) begin
      p.fv = OP_ZERO; p.ow = OP_ZERO; p.tm = OP_ZERO;
    end
    return p;
  endfunction

endpackage

// File: rtl/dfs_row_select.sv
module dfs_row_select
  import dfs_pkg::*;
(
  input  logic       trap_vld,
  input  logic [2:0] trap_cls,
  input  logic       cur_fv,
  input  logic       cur_tm,
  input  logic       sw_clr,
  output upd_pol_t   pol
);

  upd_row_e row;

  always_comb begin
    row = pick_row(trap_cls, cur_fv, cur_tm);
    if (trap_vld) pol = row_policy(row);
    else          pol = idle_policy(sw_clr);
  end

endmodule

// File: rtl/dfs_field_reg.sv
module dfs_field_reg
  import dfs_pkg::*;
#(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  fld_op_e      op,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else begin
      case (op)
        OP_LOAD: q <= d;
        OP_ZERO: q <= '0;
        OP_ONE:  q <= '1;
        default: q <= q;
      endcase
    end
  end

endmodule

// File: rtl/dfault_status.sv
module dfault_status
  import dfs_pkg::*;
#(
  parameter int TLBN_W = 2,
  parameter int IDX_W  = 9,
  parameter int CTX_W  = 2,
  parameter int ASI_W  = 8,
  parameter int ERR_W  = 5,
  parameter int VA_W   = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_vld,
  input  logic [2:0]        trap_cls,
  input  logic [TLBN_W-1:0] ev_tlb_sel,
  input  logic [IDX_W-1:0]  ev_tlb_idx,
  input  logic              ev_write,
  input  logic              ev_priv,
  input  logic              ev_nofault,
  input  logic [CTX_W-1:0]  ev_ctx,
  input  logic [6:0]        ev_ft,
  input  logic              ev_int_asi,
  input  logic [ASI_W-1:0]  ev_asi,
  input  logic [ERR_W-1:0]  ev_err,
  input  logic [VA_W-1:0]   ev_va,
  input  logic              sw_clr,
  output logic              st_fv,
  output logic              st_ow,
  output logic              st_tm,
  output logic              st_write,
  output logic              st_priv,
  output logic              st_nofault,
  output logic [CTX_W-1:0]  st_ctx,
  output logic [6:0]        st_ft,
  output logic [ASI_W-1:0]  st_asi,
  output logic [TLBN_W-1:0] st_tlb_sel,
  output logic [IDX_W-1:0]  st_tlb_idx,
  output logic [ERR_W-1:0]  st_err,
  output logic [VA_W-1:0]   st_va
);

  localparam int TLB_W  = TLBN_W + IDX_W;
  localparam int ATTR_W = 3 + CTX_W;

  upd_pol_t          pol;
  logic [FT_W-1:0]   ft_clean;
  logic [TLB_W-1:0]  tlb_q;
  logic [ATTR_W-1:0] attr_q;

  // Named events for the checks
  logic is_fault_cls;
  logic trap_on_rec;
  logic trap_on_miss;
  assign is_fault_cls = trap_vld && (trap_cls != CLS_MISS) && (trap_cls != CLS_EXC);
  assign trap_on_rec  = trap_vld && (trap_cls != CLS_MISS) && st_fv && !st_tm;
  assign trap_on_miss = trap_vld && (trap_cls != CLS_MISS) && st_tm;

  assign ft_clean = ft_filter(ev_ft, ev_int_asi);

  dfs_row_select u_sel (
    .trap_vld (trap_vld),
    .trap_cls (trap_cls),
    .cur_fv   (st_fv),
    .cur_tm   (st_tm),
    .sw_clr   (sw_clr),
    .pol      (pol)
  );

  dfs_field_reg #(.W(1)) u_fv (
    .clk(clk), .rst_n(rst_n), .op(pol.fv), .d(1'b1), .q(st_fv));
  dfs_field_reg #(.W(1)) u_ow (
    .clk(clk), .rst_n(rst_n), .op(pol.ow), .d(1'b1), .q(st_ow));
  dfs_field_reg #(.W(1)) u_tm (
    .clk(clk), .rst_n(rst_n), .op(pol.tm), .d(1'b1), .q(st_tm));
  dfs_field_reg #(.W(TLB_W)) u_tlb (
    .clk(clk), .rst_n(rst_n), .op(pol.tlb), .d({ev_tlb_sel, ev_tlb_idx}), .q(tlb_q));
  dfs_field_reg #(.W(ATTR_W)) u_attr (
    .clk(clk), .rst_n(rst_n), .op(pol.attr),
    .d({ev_write, ev_priv, ev_nofault, ev_ctx}), .q(attr_q));
  dfs_field_reg #(.W(FT_W)) u_ft (
    .clk(clk), .rst_n(rst_n), .op(pol.ft), .d(ft_clean), .q(st_ft));
  dfs_field_reg #(.W(ASI_W)) u_asi (
    .clk(clk), .rst_n(rst_n), .op(pol.asi), .d(ev_asi), .q(st_asi));
  dfs_field_reg #(.W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .op(pol.err), .d(ev_err), .q(st_err));
  dfs_field_reg #(.W(VA_W)) u_va (
    .clk(clk), .rst_n(rst_n), .op(pol.va), .d(ev_va), .q(st_va));

  assign {st_tlb_sel, st_tlb_idx}             = tlb_q;
  assign {st_write, st_priv, st_nofault, st_ctx} = attr_q;

  // R2
  miss_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_vld && trap_cls == CLS_MISS |=> st_tm && !st_fv && !st_ow && st_va == $past(ev_va));

  // R3
  fresh_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_vld && trap_cls == CLS_EXC && !st_fv && !st_tm
    |=> st_fv && !st_ow && !st_tm && st_ft == $past(ft_clean));

  // R6
  exc_on_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_on_rec |=> st_fv && st_ow && !st_tm);

  // R7
  fault_keeps_ft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_fault_cls |=> st_ft == $past(st_ft));

  // R9
  miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_on_miss |=> st_tm && st_fv && st_ow == $past(st_ow));

  // R10
  ft_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_ft[6:5] == 2'b00);

  // R11
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr && !trap_vld |=> !st_fv && !st_tm && !st_ow && st_va == $past(st_va));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_vld && !sw_clr |=> $stable(st_fv) && $stable(st_tm) && $stable(st_ft) && $stable(st_va));

endmodule

// File: tb/dfault_status_test.sv
`timescale 1ns/1ps
module dfault_status_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_vld = 1'b0;
  logic [2:0]  trap_cls = '0;
  logic [1:0]  ev_tlb_sel = '0;
  logic [8:0]  ev_tlb_idx = '0;
  logic        ev_write = 1'b0, ev_priv = 1'b0, ev_nofault = 1'b0;
  logic [1:0]  ev_ctx = '0;
  logic [6:0]  ev_ft = '0;
  logic        ev_int_asi = 1'b0;
  logic [7:0]  ev_asi = '0;
  logic [4:0]  ev_err = '0;
  logic [47:0] ev_va = '0;
  logic        sw_clr = 1'b0;
  logic        st_fv, st_ow, st_tm, st_write, st_priv, st_nofault;
  logic [1:0]  st_ctx;
  logic [6:0]  st_ft;
  logic [7:0]  st_asi;
  logic [1:0]  st_tlb_sel;
  logic [8:0]  st_tlb_idx;
  logic [4:0]  st_err;
  logic [47:0] st_va;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  dfault_status uut (
    .clk(clk), .rst_n(rst_n), .trap_vld(trap_vld), .trap_cls(trap_cls),
    .ev_tlb_sel(ev_tlb_sel), .ev_tlb_idx(ev_tlb_idx), .ev_write(ev_write),
    .ev_priv(ev_priv), .ev_nofault(ev_nofault), .ev_ctx(ev_ctx), .ev_ft(ev_ft),
    .ev_int_asi(ev_int_asi), .ev_asi(ev_asi), .ev_err(ev_err), .ev_va(ev_va),
    .sw_clr(sw_clr), .st_fv(st_fv), .st_ow(st_ow), .st_tm(st_tm),
    .st_write(st_write), .st_priv(st_priv), .st_nofault(st_nofault),
    .st_ctx(st_ctx), .st_ft(st_ft), .st_asi(st_asi), .st_tlb_sel(st_tlb_sel),
    .st_tlb_idx(st_tlb_idx), .st_err(st_err), .st_va(st_va)
  );

  // Data patterns keyed by the step that drove them; 31 stands for the reset value
  function automatic logic [47:0] va_of(input int k);
    return (k == 31) ? 48'h0 : 48'(k) * 48'h0001_0203_0405 + 48'h10;
  endfunction
  function automatic logic [4:0] attr_of(input int k);
    return (k == 31) ? 5'h0 : 5'(k + 3);
  endfunction
  function automatic logic [7:0] asi_of(input int k);
    return (k == 31) ? 8'h0 : 8'(k * 7 + 1);
  endfunction
  function automatic logic [10:0] tlb_of(input int k);
    return (k == 31) ? 11'h0 : 11'(k * 37 + 5);
  endfunction
  function automatic logic [4:0] err_of(input int k);
    return (k == 31) ? 5'h0 : 5'(k * 3 + 1);
  endfunction

  typedef struct packed {
    logic       sw;
    logic       tv;
    logic [2:0] cls;
    logic [6:0] ft;
    logic       ia;
    logic       efv;
    logic       eow;
    logic       etm;
    logic [6:0] eft;
    logic [4:0] sattr;
    logic [4:0] sasi;
    logic [4:0] stlb;
    logic [4:0] serr;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,3'd0,7'h00,1'b0, 1'b0,1'b0,1'b0,7'h00,  5'd31,5'd31,5'd31,5'd31, 4'd13}, // R13 idle
    '{1'b0,1'b1,3'd1,7'h0F,1'b0, 1'b1,1'b0,1'b0,7'h0F,  5'd1, 5'd1, 5'd31,5'd31, 4'd3 }, // R3 fresh exc
    '{1'b0,1'b1,3'd2,7'h7F,1'b0, 1'b1,1'b1,1'b0,7'h0F,  5'd2, 5'd2, 5'd2, 5'd2,  4'd7 }, // R7 fault on rec
    '{1'b0,1'b1,3'd1,7'h76,1'b1, 1'b1,1'b1,1'b0,7'h06,  5'd3, 5'd3, 5'd2, 5'd2,  4'd6 }, // R6 exc on rec
    '{1'b1,1'b0,3'd0,7'h00,1'b0, 1'b0,1'b0,1'b0,7'h06,  5'd3, 5'd3, 5'd2, 5'd2,  4'd11}, // R11 clear
    '{1'b0,1'b0,3'd0,7'h00,1'b0, 1'b0,1'b0,1'b0,7'h06,  5'd3, 5'd3, 5'd2, 5'd2,  4'd13}, // R13 hold
    '{1'b0,1'b1,3'd3,7'h01,1'b0, 1'b1,1'b0,1'b0,7'h06,  5'd6, 5'd6, 5'd2, 5'd2,  4'd4 }, // R4 fresh wp
    '{1'b1,1'b0,3'd0,7'h00,1'b0, 1'b0,1'b0,1'b0,7'h06,  5'd6, 5'd6, 5'd2, 5'd2,  4'd11}, // R11 clear
    '{1'b0,1'b1,3'd7,7'h01,1'b0, 1'b1,1'b0,1'b0,7'h06,  5'd8, 5'd8, 5'd8, 5'd8,  4'd5 }, // R5 fresh acc err
    '{1'b0,1'b1,3'd0,7'h7F,1'b0, 1'b0,1'b0,1'b1,7'h06,  5'd9, 5'd8, 5'd8, 5'd8,  4'd2 }, // R2 miss over rec
    '{1'b0,1'b1,3'd1,7'h31,1'b0, 1'b1,1'b0,1'b1,7'h11,  5'd10,5'd10,5'd8, 5'd8,  4'd8 }, // R8 exc on miss
    '{1'b0,1'b1,3'd6,7'h7F,1'b0, 1'b1,1'b0,1'b1,7'h11,  5'd11,5'd11,5'd11,5'd11, 4'd9 }, // R9 fault on miss
    '{1'b1,1'b1,3'd1,7'h02,1'b0, 1'b1,1'b0,1'b1,7'h02,  5'd12,5'd12,5'd11,5'd11, 4'd12}, // R12 trap beats clear
    '{1'b1,1'b0,3'd0,7'h00,1'b0, 1'b0,1'b0,1'b0,7'h02,  5'd12,5'd12,5'd11,5'd11, 4'd11}, // R11 clear
    '{1'b1,1'b1,3'd5,7'h04,1'b0, 1'b1,1'b0,1'b0,7'h02,  5'd14,5'd14,5'd11,5'd11, 4'd12}, // R12 fresh priv + clear
    '{1'b0,1'b1,3'd4,7'h00,1'b0, 1'b1,1'b1,1'b0,7'h02,  5'd15,5'd15,5'd15,5'd15, 4'd7 }, // R7 va wp on rec
    '{1'b0,1'b1,3'd0,7'h00,1'b0, 1'b0,1'b0,1'b1,7'h02,  5'd16,5'd15,5'd15,5'd15, 4'd2 }, // R2 miss
    '{1'b0,1'b1,3'd0,7'h00,1'b0, 1'b0,1'b0,1'b1,7'h02,  5'd17,5'd15,5'd15,5'd15, 4'd2 }, // R2 miss on miss
    '{1'b1,1'b0,3'd0,7'h00,1'b0, 1'b0,1'b0,1'b0,7'h02,  5'd17,5'd15,5'd15,5'd15, 4'd11}, // R11 clear
    '{1'b0,1'b1,3'd1,7'h1F,1'b1, 1'b1,1'b0,1'b0,7'h0F,  5'd19,5'd19,5'd15,5'd15, 4'd10}  // R10 internal ASI
  };

  task automatic chk(input int rq, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_all(input int rq, input logic fv, input logic ow, input logic tm,
                         input logic [6:0] ft, input int sa, input int ss,
                         input int st, input int se);
    chk(rq, "fv", 64'(st_fv), 64'(fv));
    chk(rq, "ow", 64'(st_ow), 64'(ow));
    chk(rq, "tm", 64'(st_tm), 64'(tm));
    chk(rq, "ft", 64'(st_ft), 64'(ft));
    chk(rq, "attr", 64'({st_write, st_priv, st_nofault, st_ctx}), 64'(attr_of(sa)));
    chk(rq, "va", 64'(st_va), 64'(va_of(sa)));
    chk(rq, "asi", 64'(st_asi), 64'(asi_of(ss)));
    chk(rq, "tlb", 64'({st_tlb_sel, st_tlb_idx}), 64'(tlb_of(st)));
    chk(rq, "err", 64'(st_err), 64'(err_of(se)));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_all(1, 1'b0, 1'b0, 1'b0, 7'h00, 31, 31, 31, 31);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      sw_clr   = v.sw;
      trap_vld = v.tv;
      trap_cls = v.cls;
      ev_ft    = v.ft;
      ev_int_asi = v.ia;
      {ev_write, ev_priv, ev_nofault, ev_ctx} = attr_of(i);
      ev_va    = va_of(i);
      ev_asi   = asi_of(i);
      {ev_tlb_sel, ev_tlb_idx} = tlb_of(i);
      ev_err   = err_of(i);
      @(posedge clk);
      @(negedge clk);
      trap_vld = 1'b0;
      sw_clr   = 1'b0;
      chk_all(int'(v.rq), v.efv, v.eow, v.etm, v.eft, int'(v.sattr), int'(v.sasi),
              int'(v.stlb), int'(v.serr));
    end

    // R1 reset in the middle of a held record
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk_all(1, 1'b0, 1'b0, 1'b0, 7'h00, 31, 31, 31, 31);
    rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule